// File: doc/BRIEF.md
# Regulator Start-Up Sequencer

This block decides when a multiphase buck regulator may leave shutdown. It then produces the digital reference code that a DAC turns into the regulation target. All analog qualification is done elsewhere. The block sees only digitized flags: the bias power-on-reset flag, the enable comparator, the driver-enable comparator and the per-phase driver bias flags. While any required flag is low, the PWM outputs are tri-stated and the reference code is zero.

Once the block is qualified, the reference rises by one LSB per step interval, so the output ramp is linear. There are two kinds of start-up:

- **Boot mode.** A fixed delay, then a ramp to a fixed boot level, then a fixed hold. At the end of the hold the VID code is sampled once and checked. A valid code starts a second ramp to that code.
- **Direct modes.** The VID target is sampled at the start and the ramp goes straight to it. In the 5-bit direct mode, the reserved all-ones "no load" code keeps the block in shutdown.

Power-good is raised only after the last ramp has finished and the window comparator input reports the output as being in regulation.

All pins are plain level signals. There is no handshake at the edge of the block: the VID bus is sampled at defined moments and is otherwise ignored.

Top module: `vr_startup_seq`

## Requirements
- R1: After reset, and whenever any of bias_por_ok, en_ok, drv_en_ok or phase_bias_ok[0] is low, the outputs are pwm_hiz=1, ref_code=0 and pgood=0.
- R2: phase_cnt encodes 00=1, 01=2, 10=3 and 11=4 phases. For 01 and 10, phase_bias_ok[2] and phase_bias_ok[1] must also be high before start-up. For 00 and 11 those two flags are ignored.
- R3: In mode 00 (boot), a qualified block first waits TD1_CYC cycles. The first rise of ref_code is seen TD1_CYC+STEP_CYC+1 cycles after the enables are applied.
- R4: Every ramp moves ref_code by exactly one LSB every STEP_CYC cycles toward its target and never skips a code. The first ramp stops at BOOT_CODE.
- R5: After the first ramp, ref_code is held at BOOT_CODE for TD3_CYC cycles. The VID is sampled only in the last hold cycle, and VID changes after the sample have no effect on ref_code.
- R6: In mode 00 a VID is valid unless it is all zeros or all ones. If the sample is invalid, ref_code stays at BOOT_CODE and pgood stays low. The VID is then rechecked every cycle, and the second ramp starts on the first valid code.
- R7: In modes 10 and 11 (5-bit), vid[4:0]=5'b11111 keeps the block in shutdown (pwm_hiz=1) while it is present.
- R8: In modes 01, 10 and 11 (direct) there is no delay and no boot stage. The target is sampled when start-up begins, and the first rise of ref_code is seen STEP_CYC+1 cycles after the enables are applied.
- R9: pgood goes high one cycle after a cycle in which the final ramp has completed and in_window is high. After that it follows in_window with one cycle of latency.
- R10: If any required qualifier falls, then at the next clock edge pwm_hiz=1, ref_code=0 and pgood=0, whatever the state.
- R11: The ramp target is the VID zero-extended in modes 00 and 01. In modes 10 and 11 it is vid[4:0] zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bias_por_ok | input | 1 | Controller bias is above its POR threshold |
| en_ok | input | 1 | Enable comparator output |
| drv_en_ok | input | 1 | Driver-enable comparator output |
| phase_bias_ok | input | 3 | Driver bias good for phases 1..3 (bit 0 = phase 1) |
| phase_cnt | input | 2 | Configured phase count minus one |
| mode | input | 2 | 00 boot, 01 direct full VID, 1x direct 5-bit VID |
| vid | input | VID_W | Parallel VID code |
| in_window | input | 1 | Output voltage is inside its regulation window |
| ref_code | output | DAC_W | Reference DAC code |
| pwm_hiz | output | 1 | Tri-state request for all PWM outputs |
| pgood | output | 1 | Power-good |

## Verification
Two functions can land in the same cycle: an abort on a falling qualifier, and a sequence step. The step may be the final ramp tick, the VID sample at the end of the hold, or a power-good update. The randomized episodes drop en_ok at random instants and toggle in_window and the VID freely, so these collisions occur repeatedly. A cycle-level expectation model in the bench gives the abort priority, and ref_code, pwm_hiz and pgood are compared against that model on every cycle.

// File: rtl/vrseq_pkg.sv
package vrseq_pkg;
  typedef enum logic [2:0] {
    ST_SHUT, ST_DELAY, ST_RAMP1, ST_HOLD, ST_VIDWAIT, ST_RAMP2, ST_DONE
  } seq_state_t;

  localparam logic [1:0] MODE_BOOT = 2'b00;
endpackage

// File: rtl/vrseq_qualify.sv
module vrseq_qualify (
  input  logic       bias_por_ok,
  input  logic       en_ok,
  input  logic       drv_en_ok,
  input  logic [2:0] phase_bias_ok,
  input  logic [1:0] phase_cnt,
  output logic       qual
);
  logic need_23;
  logic base_ok;

  // 2- and 3-phase builds also need phases 2 and 3 biased (R2)
  assign need_23 = (phase_cnt == 2'b01) || (phase_cnt == 2'b10);
  assign base_ok = bias_por_ok && en_ok && drv_en_ok && phase_bias_ok[0];
  assign qual    = base_ok && (!need_23 || (&phase_bias_ok[2:1]));
endmodule

// File: rtl/vrseq_vid.sv
module vrseq_vid #(
  parameter int VID_W = 8,
  parameter int DAC_W = 8
) (
  input  logic [VID_W-1:0] vid,
  input  logic [1:0]       mode,
  output logic [DAC_W-1:0] tgt,
  output logic             boot_valid,
  output logic             noload
);
  localparam int SHORT_W = 5;

  logic [SHORT_W-1:0] short_code;
  assign short_code = vid[SHORT_W-1:0];

  // the 5-bit modes use only the low field (R11)
  assign tgt        = mode[1] ? DAC_W'(short_code) : DAC_W'(vid);
  assign boot_valid = (vid != '0) && (vid != '1);
  assign noload     = mode[1] && (&short_code);
endmodule

// File: rtl/vrseq_ramp.sv
module vrseq_ramp #(
  parameter int DAC_W    = 8,
  parameter int STEP_CYC = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [DAC_W-1:0] tgt,
  output logic [DAC_W-1:0] ref_code,
  output logic             arrive
);
  localparam int SW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
  localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYC - 1);

  logic [DAC_W-1:0] ref_q, nxt;
  logic [SW-1:0]    step_q;
  logic             at_tgt, tick;

  assign at_tgt   = (ref_q == tgt);
  assign tick     = run && !at_tgt && (step_q == STEP_LAST);
  assign nxt      = (tgt > ref_q) ? ref_q + DAC_W'(1) : ref_q - DAC_W'(1);
  assign arrive   = run && (at_tgt || (tick && (nxt == tgt)));
  assign ref_code = ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ref_q  <= '0;
      step_q <= '0;
    end else if (!run || at_tgt) begin
      step_q <= '0;
    end else if (tick) begin
      step_q <= '0;
      ref_q  <= nxt;
    end else begin
      step_q <= step_q + SW'(1);
    end
  end

  // one LSB per step, never a jump, unless cleared (R4)
  p_unit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (ref_q == $past(ref_q) || ref_q == $past(ref_q) + DAC_W'(1)
              || ref_q == $past(ref_q) - DAC_W'(1)));

  p_idle_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !run) |=> (ref_q == $past(ref_q)));
endmodule

// File: rtl/vr_startup_seq.sv
module vr_startup_seq #(
  parameter int VID_W     = 8,
  parameter int DAC_W     = 8,
  parameter int BOOT_CODE = 110,
  parameter int TD1_CYC   = 8,
  parameter int TD3_CYC   = 6,
  parameter int STEP_CYC  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bias_por_ok,
  input  logic             en_ok,
  input  logic             drv_en_ok,
  input  logic [2:0]       phase_bias_ok,
  input  logic [1:0]       phase_cnt,
  input  logic [1:0]       mode,
  input  logic [VID_W-1:0] vid,
  input  logic             in_window,
  output logic [DAC_W-1:0] ref_code,
  output logic             pwm_hiz,
  output logic             pgood
);
  import vrseq_pkg::*;

  localparam int TMAX = (TD1_CYC > TD3_CYC) ? TD1_CYC : TD3_CYC;
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [DAC_W-1:0] BOOT_LVL = DAC_W'(BOOT_CODE);
  localparam logic [CW-1:0]    TD1_LAST = CW'(TD1_CYC - 1);
  localparam logic [CW-1:0]    TD3_LAST = CW'(TD3_CYC - 1);

  seq_state_t       state_q, state_d;
  logic [CW-1:0]    cnt_q;
  logic [DAC_W-1:0] tgt_q, tgt_d, vid_tgt, ramp_tgt;
  logic             qual, boot_valid, noload, arrive, ramp_run, ramp_clr;
  logic             pgood_q;

  vrseq_qualify u_qual (
    .bias_por_ok  (bias_por_ok),
    .en_ok        (en_ok),
    .drv_en_ok    (drv_en_ok),
    .phase_bias_ok(phase_bias_ok),
    .phase_cnt    (phase_cnt),
    .qual         (qual)
  );

  vrseq_vid #(.VID_W(VID_W), .DAC_W(DAC_W)) u_vid (
    .vid       (vid),
    .mode      (mode),
    .tgt       (vid_tgt),
    .boot_valid(boot_valid),
    .noload    (noload)
  );

  assign ramp_run = (state_q == ST_RAMP1) || (state_q == ST_RAMP2);
  assign ramp_clr = !qual || (state_q == ST_SHUT);
  assign ramp_tgt = (state_q == ST_RAMP1) ? BOOT_LVL : tgt_q;

  vrseq_ramp #(.DAC_W(DAC_W), .STEP_CYC(STEP_CYC)) u_ramp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ramp_clr),
    .run     (ramp_run),
    .tgt     (ramp_tgt),
    .ref_code(ref_code),
    .arrive  (arrive)
  );

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    if (!qual) begin
      state_d = ST_SHUT;                      // abort has priority (R10)
    end else begin
      unique case (state_q)
        ST_SHUT: if (!noload) begin
          if (mode == MODE_BOOT) begin
            state_d = ST_DELAY;
          end else begin
            state_d = ST_RAMP2;
            tgt_d   = vid_tgt;                // direct start samples target (R8)
          end
        end
        ST_DELAY: if (cnt_q == TD1_LAST) state_d = ST_RAMP1;
        ST_RAMP1: if (arrive) state_d = ST_HOLD;
        ST_HOLD: if (cnt_q == TD3_LAST) begin
          if (boot_valid) begin
            state_d = ST_RAMP2;
            tgt_d   = vid_tgt;
          end else begin
            state_d = ST_VIDWAIT;
          end
        end
        ST_VIDWAIT: if (boot_valid) begin
          state_d = ST_RAMP2;
          tgt_d   = vid_tgt;
        end
        ST_RAMP2: if (arrive) state_d = ST_DONE;
        ST_DONE:  state_d = ST_DONE;
        default:  state_d = ST_SHUT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_SHUT;
      cnt_q   <= '0;
      tgt_q   <= '0;
      pgood_q <= 1'b0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      pgood_q <= qual && (state_q == ST_DONE) && in_window;
      if (state_d != state_q || !(state_q == ST_DELAY || state_q == ST_HOLD))
        cnt_q <= '0;
      else
        cnt_q <= cnt_q + CW'(1);
    end
  end

  assign pwm_hiz = (state_q == ST_SHUT);
  assign pgood   = pgood_q;

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !qual |=> (pwm_hiz && ref_code == '0 && !pgood));

  p_bias23_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHUT && (phase_cnt == 2'b01 || phase_cnt == 2'b10)
     && !(&phase_bias_ok[2:1])) |=> (state_q == ST_SHUT));

  p_noload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHUT && noload) |=> pwm_hiz);

  p_hold_boot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HOLD) |-> (ref_code == BOOT_LVL));

  p_wait_nopg_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VIDWAIT) |-> (!pgood && ref_code == BOOT_LVL));

  p_pgood_win_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pgood |-> $past(in_window));

  p_direct_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SHUT && qual && !noload && mode != MODE_BOOT)
    |=> (state_q == ST_RAMP2));
endmodule

// File: tb/test_vr_startup_seq.sv
module test_vr_startup_seq;
  localparam int VW = 8, DW = 8, BOOT = 110, TD1 = 8, TD3 = 6, STEP = 3;
  localparam int P_SHUT = 0, P_DLY = 1, P_R1 = 2, P_HOLD = 3, P_WAIT = 4,
                 P_R2 = 5, P_DONE = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bias_por_ok = 0, en_ok = 0, drv_en_ok = 0, in_window = 0;
  logic [2:0] phase_bias_ok = 0;
  logic [1:0] phase_cnt = 0, mode = 0;
  logic [VW-1:0] vid = 0;
  logic [DW-1:0] ref_code;
  logic pwm_hiz, pgood;

  int checks = 0, errors = 0;
  bit finished = 0;
  string cur_tag = "R1";

  always #5 clk = ~clk;

  vr_startup_seq i_vr_startup_seq (
    .clk(clk), .rst_n(rst_n), .bias_por_ok(bias_por_ok), .en_ok(en_ok),
    .drv_en_ok(drv_en_ok), .phase_bias_ok(phase_bias_ok), .phase_cnt(phase_cnt),
    .mode(mode), .vid(vid), .in_window(in_window), .ref_code(ref_code),
    .pwm_hiz(pwm_hiz), .pgood(pgood));

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit f_qual();
    bit need = (phase_cnt == 2'b01) || (phase_cnt == 2'b10);
    return bias_por_ok && en_ok && drv_en_ok && phase_bias_ok[0] &&
           (!need || (phase_bias_ok[1] && phase_bias_ok[2]));
  endfunction

  function automatic int f_tgt();
    return mode[1] ? int'(vid[4:0]) : int'(vid);
  endfunction

  function automatic bit f_valid();
    return (vid != 8'h00) && (vid != 8'hFF);
  endfunction

  // expected behaviour, one update per clock edge
  int m_ph = P_SHUT, m_ref = 0, m_cnt = 0, m_step = 0, m_tgt = 0;
  bit m_pg = 0;
  always @(posedge clk) begin : model
    int t;
    bit adv, pg_n;
    if (!rst_n) begin
      m_ph = P_SHUT; m_ref = 0; m_cnt = 0; m_step = 0; m_tgt = 0; m_pg = 0;
    end else begin
      pg_n = f_qual() && (m_ph == P_DONE) && in_window;
      if (!f_qual()) begin
        m_ph = P_SHUT; m_ref = 0; m_step = 0; m_cnt = 0;
      end else begin
        case (m_ph)
          P_SHUT: if (!(mode[1] && vid[4:0] == 5'h1F)) begin
            m_step = 0; m_cnt = 0;
            if (mode == 2'b00) m_ph = P_DLY;
            else begin m_ph = P_R2; m_tgt = f_tgt(); end
          end
          P_DLY: begin
            m_cnt++;
            if (m_cnt == TD1) begin m_ph = P_R1; m_step = 0; end
          end
          P_R1, P_R2: begin
            t = (m_ph == P_R1) ? BOOT : m_tgt;
            adv = 0;
            if (m_ref == t) adv = 1;
            else begin
              m_step++;
              if (m_step == STEP) begin
                m_step = 0;
                m_ref = (t > m_ref) ? m_ref + 1 : m_ref - 1;
                if (m_ref == t) adv = 1;
              end
            end
            if (adv) begin
              m_step = 0; m_cnt = 0;
              m_ph = (m_ph == P_R1) ? P_HOLD : P_DONE;
            end
          end
          P_HOLD: begin
            m_cnt++;
            if (m_cnt == TD3) begin
              if (f_valid()) begin m_ph = P_R2; m_tgt = int'(vid); end
              else m_ph = P_WAIT;
            end
          end
          P_WAIT: if (f_valid()) begin m_ph = P_R2; m_tgt = int'(vid); end
          default: ;
        endcase
      end
      m_pg = pg_n;
    end
  end

  // every cycle: outputs against the expectation model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(ref_code) == m_ref, cur_tag, "ref_code", int'(ref_code), m_ref);
      chk(pwm_hiz == (m_ph == P_SHUT), cur_tag, "pwm_hiz", pwm_hiz, m_ph == P_SHUT);
      chk(pgood == m_pg, cur_tag, "pgood", pgood, m_pg);
    end
  end

  task automatic all_ok(logic [1:0] md, logic [VW-1:0] v);
    mode = md; vid = v; phase_cnt = 2'b00; phase_bias_ok = 3'b111;
    bias_por_ok = 1; en_ok = 1; drv_en_ok = 1;
  endtask

  task automatic drop_all();
    bias_por_ok = 0; en_ok = 0; drv_en_ok = 0; phase_bias_ok = 0;
    repeat (3) @(negedge clk);
  endtask

  task automatic cycles_to_first_step(output int k);
    k = 0;
    do begin @(negedge clk); k++; end while (ref_code != 8'd1 && k < 1000);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int k;
    int unsigned seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    chk(pwm_hiz == 1 && ref_code == 0 && pgood == 0, "R1", "reset outputs",
        {pwm_hiz, ref_code, pgood}, {1'b1, 8'd0, 1'b0});

    // R2: 2-phase config needs phase 2/3 bias; 4-phase does not
    cur_tag = "R2";
    all_ok(2'b00, 8'd150); phase_cnt = 2'b01; phase_bias_ok = 3'b101;
    repeat (20) @(negedge clk);
    chk(pwm_hiz == 1, "R2", "2-phase held", pwm_hiz, 1);
    drop_all();
    all_ok(2'b00, 8'd150); phase_cnt = 2'b11; phase_bias_ok = 3'b001;
    repeat (4) @(negedge clk);
    chk(pwm_hiz == 0, "R2", "4-phase released", pwm_hiz, 0);
    drop_all();

    // R3/R5/R9: full boot sequence to 150
    cur_tag = "R3";
    in_window = 1;
    all_ok(2'b00, 8'd150);
    cycles_to_first_step(k);
    chk(k == TD1 + STEP + 1, "R3", "cycles to first step", k, TD1 + STEP + 1);
    cur_tag = "R5";
    repeat ((BOOT - 1) * STEP + TD3 - 2) @(negedge clk);
    vid = 8'd40;   // still inside hold: this value is sampled
    repeat (3) @(negedge clk);
    vid = 8'd200;  // after the sample: ignored
    repeat ((BOOT - 40) * STEP + 10) @(negedge clk);
    chk(ref_code == 8'd40, "R5", "second ramp target", ref_code, 40);
    cur_tag = "R9";
    chk(pgood == 1, "R9", "pgood in window", pgood, 1);
    in_window = 0;
    repeat (2) @(negedge clk);
    chk(pgood == 0, "R9", "pgood out of window", pgood, 0);
    in_window = 1;

    // R10: abort mid ramp
    cur_tag = "R10";
    drop_all();
    all_ok(2'b00, 8'd90);
    repeat (100) @(negedge clk);
    en_ok = 0;
    @(negedge clk);
    chk(pwm_hiz == 1 && ref_code == 0 && pgood == 0, "R10", "abort outputs",
        {pwm_hiz, ref_code, pgood}, {1'b1, 8'd0, 1'b0});

    // R6: invalid VID holds the boot level
    cur_tag = "R6";
    drop_all();
    all_ok(2'b00, 8'h00);
    repeat (TD1 + BOOT * STEP + TD3 + 20) @(negedge clk);
    chk(ref_code == BOOT && pgood == 0, "R6", "boot level kept",
        int'(ref_code), BOOT);
    vid = 8'hFF;
    repeat (10) @(negedge clk);
    chk(ref_code == BOOT, "R6", "all-ones rejected", ref_code, BOOT);
    vid = 8'd100;
    repeat (10 * STEP + 5) @(negedge clk);
    chk(ref_code == 8'd100, "R6", "ramp after valid code", ref_code, 100);

    // R7: 5-bit no-load code blocks start
    cur_tag = "R7";
    drop_all();
    all_ok(2'b10, 8'h3F);
    repeat (50) @(negedge clk);
    chk(pwm_hiz == 1 && ref_code == 0, "R7", "no-load blocked", pwm_hiz, 1);

    // R8/R11: direct ramps
    cur_tag = "R8";
    drop_all();
    all_ok(2'b01, 8'd12);
    cycles_to_first_step(k);
    chk(k == STEP + 1, "R8", "direct first step", k, STEP + 1);
    vid = 8'd3;    // target already sampled: ignored
    repeat (12 * STEP + 5) @(negedge clk);
    chk(ref_code == 8'd12, "R8", "direct target", ref_code, 12);
    cur_tag = "R11";
    drop_all();
    all_ok(2'b11, 8'hE7);
    repeat (7 * STEP + 10) @(negedge clk);
    chk(ref_code == 8'd7, "R11", "5-bit field target", ref_code, 7);

    // R4: random episodes, collisions of abort with sequence steps
    cur_tag = "R4";
    for (int ep = 0; ep < 60; ep++) begin
      drop_all();
      all_ok(2'($urandom % 4), 8'($urandom));
      phase_cnt = 2'($urandom % 4);
      phase_bias_ok = ($urandom % 8 == 0) ? 3'b011 : 3'b111;
      for (int c = 0; c < 200 + int'($urandom % 700); c++) begin
        @(negedge clk);
        if ($urandom % 300 == 0) en_ok = 0;
        if ($urandom % 400 == 0) en_ok = 1;
        if ($urandom % 25 == 0) in_window = ~in_window;
        if ($urandom % 60 == 0) vid = 8'($urandom);
      end
    end
    finish_run();
  end
endmodule